// File: doc/BRIEF.md
# Command Strobe Window

This block turns bus accesses into one-shot actions. It stores no data. A small address window is divided into slots 0x20 bytes apart. An access to a slot fires the action tied to that slot's position. A write and a read have the same effect, and a read always returns zero. The actions are:

- single-cycle clear pulses toward the error and clock-interrupt logic around the block;
- setting or clearing a software-interrupt request that each of the two processors (the job processor and the DMA processor) can raise toward the other;
- re-arming two active-low disk-bus error flags.

The disk-side logic lowers those flags through fault inputs. Software raises them again by touching the matching slot. An address that is not aligned to a slot, and any slot with no action, does nothing.

Every action is registered. An access sampled on a clock edge shows its result in the cycle that starts at that edge.

Top module: `cs_strobe_window`

## Requirements
- R1: After reset all clear pulses are low, both software-interrupt requests are low, and both disk flags are high (no error).
- R2: An access to offset 0x20, 0xE0, 0x100, 0x120, 0x140, 0x160 or 0x180 raises, for exactly the next cycle, only the matching pulse. The pulses are, in that order: expansion-bus error clear, job clock-interrupt clear, DMA clock-interrupt clear, job bus-error clear, DMA bus-error clear, memory parity clear, switch-interrupt clear.
- R3: An access to 0x80 sets the job software-interrupt request and an access to 0x60 clears it. The request mirrors bit 3 of the processor control word, and it holds its value between accesses.
- R4: An access to 0xC0 sets the DMA software-interrupt request and an access to 0xA0 clears it. The request mirrors bit 2 of the processor control word. It is independent of the job request.
- R5: The disk parity flag (bit 13 of the disk status word) is active low. A cycle with the parity fault input high drives it low on the next cycle. An access to 0x40 drives it high again.
- R6: The disk bus-error flag (bit 12 of the disk status word) is active low. The bus fault input drives it low. An access to 0x1A0 drives it high again.
- R7: When a fault and the re-arm access for the same flag fall in the same cycle, the flag goes low.
- R8: A read strobe performs the same action as a write strobe, and the read data is always 0x0000.
- R9: An access to an address whose low five bits are not zero, to offset 0x000, or to offsets 0x1C0 and 0x1E0 causes no pulse and changes neither request nor either flag.
- R10: In a cycle with no access, no pulse is raised, and without a fault no request or flag changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_stb | input | 1 | Write access strobe |
| rd_stb | input | 1 | Read access strobe |
| addr | input | 9 | Byte offset within the window |
| rd_data | output | 16 | Read data, always zero |
| disk_par_fault | input | 1 | Disk parity fault event |
| disk_bus_fault | input | 1 | Disk bus fault event |
| xbus_err_clr | output | 1 | Expansion-bus error clear pulse |
| job_clk_clr | output | 1 | Job clock-interrupt clear pulse |
| dma_clk_clr | output | 1 | DMA clock-interrupt clear pulse |
| job_berr_clr | output | 1 | Job bus-error clear pulse |
| dma_berr_clr | output | 1 | DMA bus-error clear pulse |
| mem_par_clr | output | 1 | Memory parity error clear pulse |
| switch_int_clr | output | 1 | Switch-interrupt clear pulse |
| job_swi_req | output | 1 | Job software-interrupt request (control bit 3) |
| dma_swi_req | output | 1 | DMA software-interrupt request (control bit 2) |
| disk_par_flag_n | output | 1 | Disk parity flag, low means error (status bit 13) |
| disk_berr_flag_n | output | 1 | Disk bus-error flag, low means error (status bit 12) |

## Verification
The hardest case to reach is the collision between a fault event and the re-arm access for the same flag. It only occurs when the disk-side input and the bus strobe are presented in the same clock cycle. The stimulus drives both on one falling edge, so both are sampled by a single rising edge. The flag is then checked to still read low.

A second case needs care: near-miss addresses must be shown to have no effect. To make that visible, both requests are first set, so that a clear that fires wrongly would show. Only then are the misaligned and unused slots accessed, including one a single byte off a clear slot.

// File: rtl/cs_strobe_pkg.sv
package cs_strobe_pkg;

  // Slot numbers: slot index = offset / 0x20. The order is fixed by the address map.
  typedef enum int {
    ACT_NONE        = 0,
    ACT_XBUS_ERR    = 1,
    ACT_DPAR_REARM  = 2,
    ACT_JSWI_CLR    = 3,
    ACT_JSWI_SET    = 4,
    ACT_DSWI_CLR    = 5,
    ACT_DSWI_SET    = 6,
    ACT_JCLK_CLR    = 7,
    ACT_DCLK_CLR    = 8,
    ACT_JBERR_CLR   = 9,
    ACT_DBERR_CLR   = 10,
    ACT_MPAR_CLR    = 11,
    ACT_SWITCH_CLR  = 12,
    ACT_DBERR_REARM = 13
  } act_e;

  localparam int NUM_ACT   = 14;
  localparam int NUM_PULSE = 7;

  // Next value of a sticky request: set dominates clear (they never coincide).
  function automatic logic sticky_next(input logic cur, input logic set, input logic clr);
    if (set) return 1'b1;
    if (clr) return 1'b0;
    return cur;
  endfunction

  // Next value of an active-low flag: a fault dominates a re-arm.
  function automatic logic low_flag_next(input logic cur_n, input logic fault, input logic rearm);
    if (fault) return 1'b0;
    if (rearm) return 1'b1;
    return cur_n;
  endfunction

endpackage

// File: rtl/cs_slot_decoder.sv
module cs_slot_decoder
  import cs_strobe_pkg::*;
#(
  parameter int ADDR_W      = 9,
  parameter int STRIDE_LOG2 = 5
) (
  input  logic              access,
  input  logic [ADDR_W-1:0] addr,
  output logic [NUM_ACT-1:1] hit
);
  localparam int SLOT_W = ADDR_W - STRIDE_LOG2;

  logic              aligned;
  logic [SLOT_W-1:0] slot;

  assign aligned = (addr[STRIDE_LOG2-1:0] == '0);
  assign slot    = addr[ADDR_W-1:STRIDE_LOG2];

  for (genvar i = 1; i < NUM_ACT; i++) begin : g_slot
    assign hit[i] = access && aligned && (slot == SLOT_W'(i));
  end
endmodule

// File: rtl/cs_pulse_reg.sv
module cs_pulse_reg #(
  parameter int W = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n) q <= '0;
    else        q <= d;
  end
endmodule

// File: rtl/cs_state_bit.sv
module cs_state_bit
  import cs_strobe_pkg::*;
#(
  parameter bit ACTIVE_LOW = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raise_i,
  input  logic drop_i,
  output logic val_o
);
  // ACTIVE_LOW=0: sticky request (raise=set, drop=clear, resets to 0).
  // ACTIVE_LOW=1: error flag (raise=fault drives 0, drop=re-arm drives 1, resets to 1).
  if (ACTIVE_LOW) begin : g_flag
    always_ff @(posedge clk) begin
      if (!rst_n) val_o <= 1'b1;
      else        val_o <= low_flag_next(val_o, raise_i, drop_i);
    end
  end else begin : g_req
    always_ff @(posedge clk) begin
      if (!rst_n) val_o <= 1'b0;
      else        val_o <= sticky_next(val_o, raise_i, drop_i);
    end
  end
endmodule

// File: rtl/cs_strobe_window.sv
module cs_strobe_window
  import cs_strobe_pkg::*;
#(
  parameter int ADDR_W      = 9,
  parameter int STRIDE_LOG2 = 5,
  parameter int DATA_W      = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stb,
  input  logic              rd_stb,
  input  logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic              disk_par_fault,
  input  logic              disk_bus_fault,
  output logic              xbus_err_clr,
  output logic              job_clk_clr,
  output logic              dma_clk_clr,
  output logic              job_berr_clr,
  output logic              dma_berr_clr,
  output logic              mem_par_clr,
  output logic              switch_int_clr,
  output logic              job_swi_req,
  output logic              dma_swi_req,
  output logic              disk_par_flag_n,
  output logic              disk_berr_flag_n
);
  // Named internal events (also observed by the checker)
  logic                 access;
  logic [NUM_ACT-1:1]   hit;
  logic [NUM_PULSE-1:0] pulse_d;
  logic [NUM_PULSE-1:0] pulse_q;

  assign access  = wr_stb | rd_stb;   // a read acts exactly like a write
  assign rd_data = '0;

  cs_slot_decoder #(
    .ADDR_W      (ADDR_W),
    .STRIDE_LOG2 (STRIDE_LOG2)
  ) dec_i (
    .access (access),
    .addr   (addr),
    .hit    (hit)
  );

  // Pulse vector order: xbus, jclk, dclk, jberr, dberr, mpar, switch
  assign pulse_d = {hit[ACT_XBUS_ERR], hit[ACT_JCLK_CLR], hit[ACT_DCLK_CLR],
                    hit[ACT_JBERR_CLR], hit[ACT_DBERR_CLR], hit[ACT_MPAR_CLR],
                    hit[ACT_SWITCH_CLR]};

  cs_pulse_reg #(.W(NUM_PULSE)) pulse_i (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (pulse_d),
    .q     (pulse_q)
  );

  assign {xbus_err_clr, job_clk_clr, dma_clk_clr, job_berr_clr,
          dma_berr_clr, mem_par_clr, switch_int_clr} = pulse_q;

  cs_state_bit #(.ACTIVE_LOW(1'b0)) job_swi_i (
    .clk (clk), .rst_n (rst_n),
    .raise_i (hit[ACT_JSWI_SET]), .drop_i (hit[ACT_JSWI_CLR]),
    .val_o (job_swi_req)
  );

  cs_state_bit #(.ACTIVE_LOW(1'b0)) dma_swi_i (
    .clk (clk), .rst_n (rst_n),
    .raise_i (hit[ACT_DSWI_SET]), .drop_i (hit[ACT_DSWI_CLR]),
    .val_o (dma_swi_req)
  );

  cs_state_bit #(.ACTIVE_LOW(1'b1)) dpar_i (
    .clk (clk), .rst_n (rst_n),
    .raise_i (disk_par_fault), .drop_i (hit[ACT_DPAR_REARM]),
    .val_o (disk_par_flag_n)
  );

  cs_state_bit #(.ACTIVE_LOW(1'b1)) dberr_i (
    .clk (clk), .rst_n (rst_n),
    .raise_i (disk_bus_fault), .drop_i (hit[ACT_DBERR_REARM]),
    .val_o (disk_berr_flag_n)
  );
endmodule

// File: rtl/cs_strobe_chk.sv
module cs_strobe_chk #(
  parameter int ADDR_W = 9
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_stb,
  input logic              rd_stb,
  input logic [ADDR_W-1:0] addr,
  input logic              disk_par_fault,
  input logic              disk_bus_fault,
  input logic [6:0]        pulses,
  input logic              job_swi_req,
  input logic              dma_swi_req,
  input logic              disk_par_flag_n,
  input logic              disk_berr_flag_n
);
  logic acc;
  assign acc = wr_stb | rd_stb;

  p_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(pulses));

  p_jset_r3: assert property (@(posedge clk) disable iff (!rst_n)
    acc && addr == ADDR_W'('h80) |=> job_swi_req);
  p_jclr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    acc && addr == ADDR_W'('h60) |=> !job_swi_req);
  p_dset_r4: assert property (@(posedge clk) disable iff (!rst_n)
    acc && addr == ADDR_W'('hC0) |=> dma_swi_req);
  p_dclr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    acc && addr == ADDR_W'('hA0) |=> !dma_swi_req);

  p_pfault_r5: assert property (@(posedge clk) disable iff (!rst_n)
    disk_par_fault |=> !disk_par_flag_n);
  p_prearm_r5: assert property (@(posedge clk) disable iff (!rst_n)
    acc && addr == ADDR_W'('h40) && !disk_par_fault |=> disk_par_flag_n);
  p_bfault_r6: assert property (@(posedge clk) disable iff (!rst_n)
    disk_bus_fault |=> !disk_berr_flag_n);
  p_brearm_r6: assert property (@(posedge clk) disable iff (!rst_n)
    acc && addr == ADDR_W'('h1A0) && !disk_bus_fault |=> disk_berr_flag_n);

  p_miss_r9: assert property (@(posedge clk) disable iff (!rst_n)
    acc && addr[4:0] != 5'd0 |=> pulses == '0 && $stable(job_swi_req) && $stable(dma_swi_req));

  p_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !acc |=> pulses == '0);
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !acc && !disk_par_fault && !disk_bus_fault |=>
      $stable(job_swi_req) && $stable(dma_swi_req) &&
      $stable(disk_par_flag_n) && $stable(disk_berr_flag_n));
endmodule

bind cs_strobe_window cs_strobe_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk              (clk),
  .rst_n            (rst_n),
  .wr_stb           (wr_stb),
  .rd_stb           (rd_stb),
  .addr             (addr),
  .disk_par_fault   (disk_par_fault),
  .disk_bus_fault   (disk_bus_fault),
  .pulses           (pulse_q),
  .job_swi_req      (job_swi_req),
  .dma_swi_req      (dma_swi_req),
  .disk_par_flag_n  (disk_par_flag_n),
  .disk_berr_flag_n (disk_berr_flag_n)
);

// File: tb/cs_strobe_window_tb.sv
module cs_strobe_window_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_stb = 1'b0, rd_stb = 1'b0;
  logic [8:0]  addr = '0;
  logic [15:0] rd_data;
  logic        disk_par_fault = 1'b0, disk_bus_fault = 1'b0;
  logic        xbus_err_clr, job_clk_clr, dma_clk_clr, job_berr_clr;
  logic        dma_berr_clr, mem_par_clr, switch_int_clr;
  logic        job_swi_req, dma_swi_req, disk_par_flag_n, disk_berr_flag_n;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;
  logic [15:0] seen_rd;

  always #10 clk = ~clk;   // 50 MHz

  cs_strobe_window dut_i (
    .clk (clk), .rst_n (rst_n), .wr_stb (wr_stb), .rd_stb (rd_stb),
    .addr (addr), .rd_data (rd_data),
    .disk_par_fault (disk_par_fault), .disk_bus_fault (disk_bus_fault),
    .xbus_err_clr (xbus_err_clr), .job_clk_clr (job_clk_clr),
    .dma_clk_clr (dma_clk_clr), .job_berr_clr (job_berr_clr),
    .dma_berr_clr (dma_berr_clr), .mem_par_clr (mem_par_clr),
    .switch_int_clr (switch_int_clr), .job_swi_req (job_swi_req),
    .dma_swi_req (dma_swi_req), .disk_par_flag_n (disk_par_flag_n),
    .disk_berr_flag_n (disk_berr_flag_n)
  );

  function automatic logic [6:0] pulses_now();
    return {xbus_err_clr, job_clk_clr, dma_clk_clr, job_berr_clr,
            dma_berr_clr, mem_par_clr, switch_int_clr};
  endfunction

  // Expected pulse vector from the address map (order as in R2)
  function automatic logic [6:0] exp_pulse(input logic [8:0] a);
    case (a)
      9'h020:  return 7'b1000000;
      9'h0E0:  return 7'b0100000;
      9'h100:  return 7'b0010000;
      9'h120:  return 7'b0001000;
      9'h140:  return 7'b0000100;
      9'h160:  return 7'b0000010;
      9'h180:  return 7'b0000001;
      default: return 7'b0000000;
    endcase
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One access cycle; returns at the falling edge after the sampling edge
  task automatic do_access(input logic [8:0] a, input bit is_read);
    @(negedge clk);
    addr = a; wr_stb = !is_read; rd_stb = is_read;
    #1 seen_rd = rd_data;
    @(negedge clk);
    wr_stb = 1'b0; rd_stb = 1'b0; addr = '0;
  endtask

  task automatic t_reset();
    check("R1 pulses", {9'd0, pulses_now()}, 16'h0);
    check("R1 requests", {14'd0, job_swi_req, dma_swi_req}, 16'h0);
    check("R1 flags", {14'd0, disk_par_flag_n, disk_berr_flag_n}, 16'h3);
  endtask

  task automatic t_pulses();
    logic [8:0] list [7] = '{9'h020, 9'h0E0, 9'h100, 9'h120, 9'h140, 9'h160, 9'h180};
    for (int i = 0; i < 7; i++) begin
      do_access(list[i], 1'b0);
      check("R2 pulse", {9'd0, pulses_now()}, {9'd0, exp_pulse(list[i])});
      @(negedge clk);
      check("R10 pulse one cycle", {9'd0, pulses_now()}, 16'h0);
    end
  endtask

  task automatic t_job_swi();
    do_access(9'h080, 1'b0);
    check("R3 job set", {15'd0, job_swi_req}, 16'h1);
    repeat (3) @(negedge clk);
    check("R10 job holds", {15'd0, job_swi_req}, 16'h1);
    check("R3 dma untouched", {15'd0, dma_swi_req}, 16'h0);
    do_access(9'h060, 1'b0);
    check("R3 job clear", {15'd0, job_swi_req}, 16'h0);
  endtask

  task automatic t_dma_swi();
    do_access(9'h0C0, 1'b0);
    check("R4 dma set", {15'd0, dma_swi_req}, 16'h1);
    check("R4 job untouched", {15'd0, job_swi_req}, 16'h0);
    do_access(9'h0A0, 1'b0);
    check("R4 dma clear", {15'd0, dma_swi_req}, 16'h0);
  endtask

  task automatic t_disk_par();
    @(negedge clk); disk_par_fault = 1'b1;
    @(negedge clk); disk_par_fault = 1'b0;
    check("R5 parity fault", {15'd0, disk_par_flag_n}, 16'h0);
    check("R5 bus flag untouched", {15'd0, disk_berr_flag_n}, 16'h1);
    repeat (2) @(negedge clk);
    check("R10 flag holds", {15'd0, disk_par_flag_n}, 16'h0);
    do_access(9'h040, 1'b0);
    check("R5 parity rearm", {15'd0, disk_par_flag_n}, 16'h1);
  endtask

  task automatic t_disk_bus();
    @(negedge clk); disk_bus_fault = 1'b1;
    @(negedge clk); disk_bus_fault = 1'b0;
    check("R6 bus fault", {15'd0, disk_berr_flag_n}, 16'h0);
    do_access(9'h1A0, 1'b0);
    check("R6 bus rearm", {15'd0, disk_berr_flag_n}, 16'h1);
  endtask

  task automatic t_collide();
    @(negedge clk);
    disk_par_fault = 1'b1; addr = 9'h040; wr_stb = 1'b1;
    @(negedge clk);
    disk_par_fault = 1'b0; wr_stb = 1'b0; addr = '0;
    check("R7 parity fault wins", {15'd0, disk_par_flag_n}, 16'h0);
    @(negedge clk);
    disk_bus_fault = 1'b1; addr = 9'h1A0; rd_stb = 1'b1;
    @(negedge clk);
    disk_bus_fault = 1'b0; rd_stb = 1'b0; addr = '0;
    check("R7 bus fault wins", {15'd0, disk_berr_flag_n}, 16'h0);
    do_access(9'h040, 1'b0);
    do_access(9'h1A0, 1'b0);
    check("R7 both rearmed", {14'd0, disk_par_flag_n, disk_berr_flag_n}, 16'h3);
  endtask

  task automatic t_reads();
    do_access(9'h080, 1'b1);
    check("R8 read sets job", {15'd0, job_swi_req}, 16'h1);
    check("R8 read data zero", seen_rd, 16'h0);
    do_access(9'h120, 1'b1);
    check("R8 read pulse", {9'd0, pulses_now()}, {9'd0, exp_pulse(9'h120)});
    check("R8 read data zero", seen_rd, 16'h0);
    do_access(9'h060, 1'b1);
    check("R8 read clears job", {15'd0, job_swi_req}, 16'h0);
  endtask

  task automatic t_misses();
    logic [8:0] list [6] = '{9'h000, 9'h061, 9'h0A8, 9'h1C0, 9'h1E0, 9'h04F};
    do_access(9'h080, 1'b0);
    do_access(9'h0C0, 1'b0);
    @(negedge clk); disk_par_fault = 1'b1;
    @(negedge clk); disk_par_fault = 1'b0;
    for (int i = 0; i < 6; i++) begin
      do_access(list[i], i[0]);
      check("R9 no pulse", {9'd0, pulses_now()}, 16'h0);
      check("R9 state kept", {12'd0, job_swi_req, dma_swi_req, disk_par_flag_n, disk_berr_flag_n},
            16'b1101);
    end
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_pulses();
    t_job_swi();
    t_dma_swi();
    t_disk_par();
    t_disk_bus();
    t_collide();
    t_reads();
    t_misses();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule